// File: doc/BRIEF.md
# Complementary Output Dead-Time Generator

This block turns one reference PWM waveform into a complementary pair of outputs, a high-side drive and a low-side drive. On every edge of the reference, the output that is about to turn on waits for a programmable dead time. The output that is turning off drops at once, so the two drives are never active together. The dead time is counted in periods of the block clock, which is the dead-time sampling clock. It is selected by an 8-bit code that is decoded piecewise over four ranges. Each range has its own base offset and step size, so short delays get fine resolution and long delays still fit in the code.

When the main output enable is low, the pair leaves normal switching. An off-state select input then picks one of two behaviours. In the first, both output enables are released. In the second, each output whose channel enable is set is held at its programmed idle level, with its output enable asserted.

Top module: `cdt_pair`

## Requirements
- R1: For codes with bit 7 = 0, the dead time is the code value in clock cycles (0 to 127).
- R2: For codes with bits 7:6 = 10, the dead time is (64 + code[5:0]) × 2 cycles (128 to 254).
- R3: For codes with bits 7:5 = 110, the dead time is (32 + code[4:0]) × 8 cycles (256 to 504).
- R4: For codes with bits 7:5 = 111, the dead time is (32 + code[4:0]) × 16 cycles (512 to 1008).
- R5: When the reference is first sampled high at clock edge k, `ocn_o` is 0 right after edge k, and `oc_o` becomes 1 right after edge k + DT.
- R6: When the reference is first sampled low at clock edge k, `oc_o` is 0 right after edge k, and `ocn_o` becomes 1 right after edge k + DT.
- R7: While `moe_i` is 1, `oc_o` and `ocn_o` are never 1 at the same time.
- R8: If a reference level lasts fewer cycles than the dead time, the delayed output for that level never becomes 1.
- R9: While `moe_i` is 1, each output enable equals its channel enable and each output carries its dead-time-delayed signal; `ossi_i` has no effect.
- R10: While `moe_i` is 0 and `ossi_i` is 0, both output enables are 0 and each output value equals its idle level.
- R11: While `moe_i` is 0 and `ossi_i` is 1, each output value equals its idle level and each output enable equals its channel enable.
- R12: After reset, with the reference low, `oc_o` is 0 and `ocn_o` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Dead-time sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_i | input | 1 | Reference PWM waveform |
| dt_code_i | input | 8 | Dead-time code |
| moe_i | input | 1 | Main output enable |
| ossi_i | input | 1 | Off-state select used while the main enable is low |
| oc_en_i | input | 1 | Channel enable for the high-side output |
| ocn_en_i | input | 1 | Channel enable for the low-side output |
| oc_idle_i | input | 1 | Idle level of the high-side output |
| ocn_idle_i | input | 1 | Idle level of the low-side output |
| oc_o | output | 1 | High-side output value |
| ocn_o | output | 1 | Low-side output value |
| oc_oe_o | output | 1 | High-side output enable |
| ocn_oe_o | output | 1 | Low-side output enable |

## Verification
The hardest cases to reach are the exact cycle counts at every range boundary of the code, and the far end of the longest range, where a single reference edge needs over a thousand cycles to resolve. The stimulus walks all 256 codes. For each code it drives a rising edge and then a falling edge. It counts cycles from the first sampled edge until the delayed output turns on, and compares that count with a model computed in the bench from the range formulas. A pulse shorter than its dead time is also driven, to confirm that the delayed output stays off for the whole pulse.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
   // decode constants for the four code ranges
   localparam int CODE_W   = 8;
   localparam int BASE_MID = 64;   // base of the x2 range
   localparam int BASE_HI  = 32;   // base of the x8 and x16 ranges
   localparam int SH_MID   = 1;    // x2
   localparam int SH_HI0   = 3;    // x8
   localparam int SH_HI1   = 4;    // x16
   localparam int DT_MAX   = (BASE_HI + 31) << SH_HI1;
   localparam int CNT_W    = $clog2(DT_MAX + 1);

   typedef logic [CNT_W-1:0] dt_cnt_t;

   // index of each output lane
   typedef enum logic {LANE_OC = 1'b0, LANE_OCN = 1'b1} lane_e;
endpackage

// File: rtl/cdt_decode.sv
module cdt_decode
   import cdt_pkg::*;
#(
   parameter int CODE_BITS = CODE_W
) (
   input  logic [CODE_BITS-1:0] code_i,
   output dt_cnt_t              dt_o
);
   generate
      if (CODE_BITS != 8) begin : g_bad_width
         $error("cdt_decode: code width must be 8");
      end
   endgenerate

   always_comb begin
      if (!code_i[7]) begin
         dt_o = dt_cnt_t'(code_i[6:0]);
      end else if (!code_i[6]) begin
         dt_o = dt_cnt_t'((BASE_MID + int'(code_i[5:0])) << SH_MID);
      end else if (!code_i[5]) begin
         dt_o = dt_cnt_t'((BASE_HI + int'(code_i[4:0])) << SH_HI0);
      end else begin
         dt_o = dt_cnt_t'((BASE_HI + int'(code_i[4:0])) << SH_HI1);
      end
   end
endmodule

// File: rtl/cdt_timer.sv
module cdt_timer
   import cdt_pkg::*;
(
   input  logic    clk_i,
   input  logic    rst_ni,
   input  logic    ref_i,
   input  dt_cnt_t dt_i,
   output logic    act_oc_o,
   output logic    act_ocn_o
);
   logic    ref_q;
   dt_cnt_t cnt_q;
   logic    expired;

   assign expired = (cnt_q == '0);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ref_q <= 1'b0;
         cnt_q <= '0;
      end else begin
         ref_q <= ref_i;
         if (ref_i != ref_q) begin
            cnt_q <= dt_i;
         end else if (!expired) begin
            cnt_q <= cnt_q - 1'b1;
         end
      end
   end

   assign act_oc_o  = ref_q  & expired;
   assign act_ocn_o = ~ref_q & expired;
endmodule

// File: rtl/cdt_outstage.sv
module cdt_outstage #(
   parameter int  LANES   = 2,
   parameter bit  OUT_REG = 1'b0
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             moe_i,
   input  logic             ossi_i,
   input  logic [LANES-1:0] act_i,
   input  logic [LANES-1:0] en_i,
   input  logic [LANES-1:0] idle_i,
   output logic [LANES-1:0] val_o,
   output logic [LANES-1:0] oe_o
);
   logic [LANES-1:0] val_d;
   logic [LANES-1:0] oe_d;

   generate
      for (genvar i = 0; i < LANES; i++) begin : g_lane
         always_comb begin
            if (moe_i) begin
               val_d[i] = act_i[i];
               oe_d[i]  = en_i[i];
            end else begin
               val_d[i] = idle_i[i];
               oe_d[i]  = ossi_i & en_i[i];
            end
         end
      end

      if (OUT_REG) begin : g_reg
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               val_o <= '0;
               oe_o  <= '0;
            end else begin
               val_o <= val_d;
               oe_o  <= oe_d;
            end
         end
      end else begin : g_comb
         assign val_o = val_d;
         assign oe_o  = oe_d;
      end
   endgenerate
endmodule

// File: rtl/cdt_pair.sv
module cdt_pair
   import cdt_pkg::*;
#(
   parameter int CODE_BITS = CODE_W,
   parameter bit OUT_REG   = 1'b0
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 ref_i,
   input  logic [CODE_BITS-1:0] dt_code_i,
   input  logic                 moe_i,
   input  logic                 ossi_i,
   input  logic                 oc_en_i,
   input  logic                 ocn_en_i,
   input  logic                 oc_idle_i,
   input  logic                 ocn_idle_i,
   output logic                 oc_o,
   output logic                 ocn_o,
   output logic                 oc_oe_o,
   output logic                 ocn_oe_o
);
   localparam int LANES = 2;

   dt_cnt_t          dt;
   logic             act_oc, act_ocn;
   logic [LANES-1:0] act, en, idle, val, oe;

   cdt_decode #(.CODE_BITS(CODE_BITS)) u_decode (
      .code_i (dt_code_i),
      .dt_o   (dt)
   );

   cdt_timer u_timer (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .ref_i     (ref_i),
      .dt_i      (dt),
      .act_oc_o  (act_oc),
      .act_ocn_o (act_ocn)
   );

   assign act[LANE_OC]   = act_oc;
   assign act[LANE_OCN]  = act_ocn;
   assign en[LANE_OC]    = oc_en_i;
   assign en[LANE_OCN]   = ocn_en_i;
   assign idle[LANE_OC]  = oc_idle_i;
   assign idle[LANE_OCN] = ocn_idle_i;

   cdt_outstage #(.LANES(LANES), .OUT_REG(OUT_REG)) u_out (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .moe_i  (moe_i),
      .ossi_i (ossi_i),
      .act_i  (act),
      .en_i   (en),
      .idle_i (idle),
      .val_o  (val),
      .oe_o   (oe)
   );

   assign oc_o     = val[LANE_OC];
   assign ocn_o    = val[LANE_OCN];
   assign oc_oe_o  = oe[LANE_OC];
   assign ocn_oe_o = oe[LANE_OCN];
endmodule

// File: rtl/cdt_pair_chk.sv
module cdt_pair_chk #(
   parameter bit OUT_REG = 1'b0
) (
   input logic clk_i,
   input logic rst_ni,
   input logic ref_i,
   input logic moe_i,
   input logic ossi_i,
   input logic oc_en_i,
   input logic ocn_en_i,
   input logic oc_idle_i,
   input logic ocn_idle_i,
   input logic oc_o,
   input logic ocn_o,
   input logic oc_oe_o,
   input logic ocn_oe_o
);
   generate
      if (!OUT_REG) begin : g_comb_chk
         // R7
         no_overlap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            moe_i |-> !(oc_o && ocn_o));

         // R5
         low_side_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $rose(ref_i) |=> (!moe_i || !ocn_o));

         // R6
         high_side_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $fell(ref_i) |=> (!moe_i || !oc_o));

         // R9
         run_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            moe_i |-> (oc_oe_o == oc_en_i && ocn_oe_o == ocn_en_i));

         // R10
         off_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!moe_i && !ossi_i) |-> (!oc_oe_o && !ocn_oe_o));

         // R11
         idle_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!moe_i && ossi_i) |-> (oc_o == oc_idle_i && ocn_o == ocn_idle_i
                                    && oc_oe_o == oc_en_i && ocn_oe_o == ocn_en_i));
      end
   endgenerate
endmodule

bind cdt_pair cdt_pair_chk #(.OUT_REG(OUT_REG)) u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .ref_i      (ref_i),
   .moe_i      (moe_i),
   .ossi_i     (ossi_i),
   .oc_en_i    (oc_en_i),
   .ocn_en_i   (ocn_en_i),
   .oc_idle_i  (oc_idle_i),
   .ocn_idle_i (ocn_idle_i),
   .oc_o       (oc_o),
   .ocn_o      (ocn_o),
   .oc_oe_o    (oc_oe_o),
   .ocn_oe_o   (ocn_oe_o)
);

// File: tb/cdt_pair_tb.sv
module cdt_pair_tb;
   logic       clk_i = 1'b0;
   logic       rst_ni = 1'b0;
   logic       ref_i = 1'b0;
   logic [7:0] dt_code_i = 8'd0;
   logic       moe_i = 1'b1;
   logic       ossi_i = 1'b0;
   logic       oc_en_i = 1'b1;
   logic       ocn_en_i = 1'b1;
   logic       oc_idle_i = 1'b0;
   logic       ocn_idle_i = 1'b0;
   logic       oc_o, ocn_o, oc_oe_o, ocn_oe_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk_i = ~clk_i;

   cdt_pair u_dut (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .ref_i      (ref_i),
      .dt_code_i  (dt_code_i),
      .moe_i      (moe_i),
      .ossi_i     (ossi_i),
      .oc_en_i    (oc_en_i),
      .ocn_en_i   (ocn_en_i),
      .oc_idle_i  (oc_idle_i),
      .ocn_idle_i (ocn_idle_i),
      .oc_o       (oc_o),
      .ocn_o      (ocn_o),
      .oc_oe_o    (oc_oe_o),
      .ocn_oe_o   (ocn_oe_o)
   );

   // fields: moe ossi oc_en ocn_en oc_idle ocn_idle ref | exp oc_oe ocn_oe oc ocn
   localparam logic [10:0] VEC [8] = '{
      11'b1011001_1110,
      11'b1010110_1001,
      11'b1101001_0110,
      11'b0011101_0010,
      11'b0011010_0001,
      11'b0111100_1110,
      11'b0110011_1001,
      11'b0101111_0111
   };

   function automatic int model_dt(input int c);
      if (c < 128)      return c;
      else if (c < 192) return (c - 128 + 64) * 2;
      else if (c < 224) return (c - 192 + 32) * 8;
      else              return (c - 224 + 32) * 16;
   endfunction

   function automatic string range_tag(input int c);
      if (c < 128)      return "R1";
      else if (c < 192) return "R2";
      else if (c < 224) return "R3";
      else              return "R4";
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic settle(input int n);
      repeat (n) @(negedge clk_i);
   endtask

   // drive ref to lvl, return cycles until the delayed output turns on
   task automatic edge_count(input logic lvl, output int n);
      @(negedge clk_i);
      ref_i = lvl;
      @(posedge clk_i);
      #1;
      n = 0;
      while ((lvl ? oc_o : ocn_o) == 1'b0 && n < 1200) begin
         @(posedge clk_i);
         #1;
         n++;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk_i);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      int n;
      settle(3);
      #1;
      // R12 reset state
      chk("R12 oc", int'(oc_o), 0);
      chk("R12 ocn", int'(ocn_o), 1);
      @(negedge clk_i);
      rst_ni = 1'b1;
      settle(2);

      // idle and enable vector table
      foreach (VEC[i]) begin
         @(negedge clk_i);
         ref_i = VEC[i][4];
         dt_code_i = 8'd0;
         moe_i = 1'b1;
         settle(3);
         moe_i      = VEC[i][10];
         ossi_i     = VEC[i][9];
         oc_en_i    = VEC[i][8];
         ocn_en_i   = VEC[i][7];
         oc_idle_i  = VEC[i][6];
         ocn_idle_i = VEC[i][5];
         #1;
         begin
            string t;
            t = VEC[i][10] ? "R9" : (VEC[i][9] ? "R11" : "R10");
            chk({t, " oc_oe"},  int'(oc_oe_o),  int'(VEC[i][3]));
            chk({t, " ocn_oe"}, int'(ocn_oe_o), int'(VEC[i][2]));
            chk({t, " oc"},     int'(oc_o),     int'(VEC[i][1]));
            chk({t, " ocn"},    int'(ocn_o),    int'(VEC[i][0]));
         end
      end

      // back to run mode with ref low and counter expired
      @(negedge clk_i);
      moe_i = 1'b1; ossi_i = 1'b0; oc_en_i = 1'b1; ocn_en_i = 1'b1;
      ref_i = 1'b0;
      settle(3);

      // full code sweep: R1..R4 decode, R5 / R6 edge timing
      for (int c = 0; c < 256; c++) begin
         @(negedge clk_i);
         dt_code_i = 8'(c);
         @(negedge clk_i);
         ref_i = 1'b1;
         @(posedge clk_i);
         #1;
         chk("R5 ocn drop", int'(ocn_o), 0);
         n = 0;
         while (oc_o == 1'b0 && n < 1200) begin
            @(posedge clk_i);
            #1;
            n++;
         end
         chk({range_tag(c), " R5 rise delay"}, n, model_dt(c));
         @(negedge clk_i);
         ref_i = 1'b0;
         @(posedge clk_i);
         #1;
         chk("R6 oc drop", int'(oc_o), 0);
         n = 0;
         while (ocn_o == 1'b0 && n < 1200) begin
            @(posedge clk_i);
            #1;
            n++;
         end
         chk({range_tag(c), " R6 fall delay"}, n, model_dt(c));
      end

      // R8 short pulse: dead time 20, pulse of 5 cycles
      @(negedge clk_i);
      dt_code_i = 8'd20;
      settle(2);
      ref_i = 1'b1;
      begin
         int seen;
         seen = 0;
         repeat (5) begin
            @(posedge clk_i);
            #1;
            seen |= int'(oc_o);
         end
         @(negedge clk_i);
         ref_i = 1'b0;
         repeat (40) begin
            @(posedge clk_i);
            #1;
            seen |= int'(oc_o);
         end
         chk("R8 oc stays off", seen, 0);
         chk("R8 ocn returns", int'(ocn_o), 1);
      end

      // R5 with code at top of the x16 range, single edge re-check
      @(negedge clk_i);
      dt_code_i = 8'hFF;
      edge_count(1'b1, n);
      chk("R4 R5 max delay", n, 1008);
      edge_count(1'b0, n);
      chk("R4 R6 max delay", n, 1008);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule